// File: doc/BRIEF.md
# Memory Error Injection Controller

This block sits on the write path of an ECC memory controller, between the ECC encoder and the DRAM interface. It deliberately corrupts data, check bits or parity of selected writes so that the downstream error detection and reporting logic can be exercised. Software programs a target address through six match fields: module within the channel, rank, channel, bank, page and column. Each field carries its own wildcard bit. Software also programs a 64-bit corruption mask, a half-word section select, a corruption kind and an enable.

Every write access passes through a single register stage. When injection is enabled, the section select is nonzero and all six fields match, the block XORs the mask into the chosen halves of the 128-bit data word. Instead of the data, it can flip the check byte or the parity bit of each selected half. Each injection raises a one-cycle pulse and advances a 32-bit counter, so a testbench can account for every corrupted write. In one-shot mode the enable drops after the first injection. In repeat mode it stays set until software clears it.

Top module: `mem_err_inject`

## Requirements
- R1: After reset, every match field register reads with its wildcard bit (bit 31) set and value 0. The mask, control, enable and count registers all read 0.
- R2: An access is a match only when `acc_valid_i` is high and, for each of the six fields, either the wildcard bit is set or the stored value equals the access field. A mismatch on any single field, including column alone, prevents injection.
- R3: Section select (control bits 1:0) chooses the halves. Value 1 selects the lower half (data bits 63:0, check bits 7:0, parity bit 0). Value 2 selects the upper half (data 127:64, check 15:8, parity 1). Value 3 selects both halves. Value 0 suppresses injection and leaves the enable set.
- R4: Control bit 3 XORs mask bits 7:0 into the check byte of each selected half. Control bit 4 inverts the parity bit of each selected half. When both bits are clear, the 64-bit mask is XORed into the data of each selected half; for example, a mask of 64 flips bit 6 of the half.
- R5: With control bit 2 (repeat) clear, the enable clears itself after the first injection. With it set, every matching write is corrupted until software writes zero to the enable.
- R6: Writing a nonzero value to the enable register starts injection, and writing zero stops it. While disabled, no access is altered.
- R7: Every access appears on the outputs exactly one clock after it is presented. Accesses that are not injected leave the block unchanged.
- R8: Each injection produces a one-cycle `inj_pulse_o` aligned with the corrupted output, and increments the count readable at address 10 and on `inj_count_o`.
- R9: Register map: addresses 0–5 hold module, rank, channel, bank, page and column (value in the low bits, wildcard in bit 31). Address 6 holds mask bits 31:0 and address 7 mask bits 63:32. Address 8 is control, 9 is enable (bit 0) and 10 is count (read only). Field values are truncated to the field width on write (2, 2, 2, 4, 16, 12 bits).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_valid_i | input | 1 | Register access strobe |
| reg_write_i | input | 1 | 1 = write, 0 = read |
| reg_addr_i | input | 4 | Register address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data, combinational, 0 when no read |
| acc_valid_i | input | 1 | Write access valid |
| acc_dimm_i | input | 2 | Module index within channel |
| acc_rank_i | input | 2 | Rank |
| acc_chan_i | input | 2 | Channel |
| acc_bank_i | input | 4 | Bank |
| acc_page_i | input | 16 | Page (row) |
| acc_col_i | input | 12 | Column |
| acc_data_i | input | 128 | Write data |
| acc_ecc_i | input | 16 | Check bits, one byte per half |
| acc_par_i | input | 2 | Parity bits, one per half |
| acc_valid_o | output | 1 | Registered access valid |
| acc_data_o | output | 128 | Data after optional corruption |
| acc_ecc_o | output | 16 | Check bits after optional corruption |
| acc_par_o | output | 2 | Parity after optional corruption |
| inj_pulse_o | output | 1 | High for the cycle of an injected output |
| inj_count_o | output | 32 | Injection count |

## Verification
On every cycle, the assertions check several properties. Non-injected accesses pass through unchanged one cycle later. A lower-half-only injection never touches the upper half. Check-byte injection never alters data. A one-shot injection drops the enable. Each pulse coincides with a single step of the counter. Only the bench scenarios can show field-by-field matching and wildcards, the exact bits flipped for each section and kind, parity inversion, and register readback with truncation. They also show that section 0 holds the enable and that repeat mode keeps corrupting until software stops it.

// File: rtl/mei_pkg.sv
package mei_pkg;
  localparam int NF = 6;       // match fields
  localparam int FW = 16;      // stored field width (widest field)
  localparam int DW = 128;     // data word
  localparam int HW = DW / 2;  // half word, also mask width
  localparam int EW = 8;       // check bits per half
  localparam int AW = 4;
  localparam int RW = 32;
  localparam int CW = 32;

  localparam logic [AW-1:0] A_MASK_LO = 4'd6;
  localparam logic [AW-1:0] A_MASK_HI = 4'd7;
  localparam logic [AW-1:0] A_CTRL    = 4'd8;
  localparam logic [AW-1:0] A_EN      = 4'd9;
  localparam logic [AW-1:0] A_CNT     = 4'd10;

  typedef struct packed {
    logic par;
    logic ecc;
    logic rpt;
  } inj_kind_t;

  function automatic int fld_width(input int f);
    case (f)
      0, 1, 2: return 2;
      3:       return 4;
      4:       return 16;
      default: return 12;
    endcase
  endfunction

  function automatic logic [FW-1:0] fld_limit(input int f);
    logic [31:0] lim;
    lim = (32'd1 << fld_width(f)) - 32'd1;
    return lim[FW-1:0];
  endfunction
endpackage

// File: rtl/mei_regs.sv
module mei_regs
  import mei_pkg::*;
(
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   reg_valid_i,
  input  logic                   reg_write_i,
  input  logic [AW-1:0]          reg_addr_i,
  input  logic [RW-1:0]          reg_wdata_i,
  output logic [RW-1:0]          reg_rdata_o,
  input  logic                   inj_hit_i,
  output logic [NF-1:0][FW-1:0]  fld_val_o,
  output logic [NF-1:0]          fld_any_o,
  output logic [HW-1:0]          mask_o,
  output logic [1:0]             sect_o,
  output inj_kind_t              kind_o,
  output logic                   en_o,
  output logic [CW-1:0]          cnt_o
);
  logic wr;
  assign wr = reg_valid_i && reg_write_i;

  for (genvar f = 0; f < NF; f++) begin : g_fld
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        fld_val_o[f] <= '0;
        fld_any_o[f] <= 1'b1;
      end else if (wr && reg_addr_i == AW'(f)) begin
        fld_val_o[f] <= reg_wdata_i[FW-1:0] & fld_limit(f);
        fld_any_o[f] <= reg_wdata_i[RW-1];
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mask_o <= '0;
      sect_o <= '0;
      kind_o <= '0;
    end else if (wr) begin
      if (reg_addr_i == A_MASK_LO) mask_o[RW-1:0]  <= reg_wdata_i;
      if (reg_addr_i == A_MASK_HI) mask_o[HW-1:RW] <= reg_wdata_i;
      if (reg_addr_i == A_CTRL) begin
        sect_o <= reg_wdata_i[1:0];
        kind_o <= reg_wdata_i[4:2];
      end
    end
  end

  // software write wins over one-shot self clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         en_o <= 1'b0;
    else if (wr && reg_addr_i == A_EN)   en_o <= |reg_wdata_i;
    else if (inj_hit_i && !kind_o.rpt)   en_o <= 1'b0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        cnt_o <= '0;
    else if (inj_hit_i) cnt_o <= cnt_o + CW'(1);
  end

  always_comb begin
    reg_rdata_o = '0;
    if (reg_valid_i && !reg_write_i) begin
      for (int f = 0; f < NF; f++) begin
        if (reg_addr_i == AW'(f)) begin
          reg_rdata_o[FW-1:0] = fld_val_o[f];
          reg_rdata_o[RW-1]   = fld_any_o[f];
        end
      end
      case (reg_addr_i)
        A_MASK_LO: reg_rdata_o = mask_o[RW-1:0];
        A_MASK_HI: reg_rdata_o = mask_o[HW-1:RW];
        A_CTRL:    reg_rdata_o = {27'd0, kind_o, sect_o};
        A_EN:      reg_rdata_o = {31'd0, en_o};
        A_CNT:     reg_rdata_o = cnt_o;
        default:   ;
      endcase
    end
  end

  a_r5_one_shot_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_hit_i && !kind_o.rpt && !(wr && reg_addr_i == A_EN) |=> !en_o);

  a_r5_repeat_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_hit_i && kind_o.rpt && !wr |=> en_o);
endmodule

// File: rtl/mei_match.sv
module mei_match
  import mei_pkg::*;
(
  input  logic [NF-1:0][FW-1:0] fld_val_i,
  input  logic [NF-1:0]         fld_any_i,
  input  logic [NF-1:0][FW-1:0] acc_fld_i,
  output logic                  match_o
);
  logic [NF-1:0] fld_ok;

  for (genvar f = 0; f < NF; f++) begin : g_cmp
    assign fld_ok[f] = fld_any_i[f] || (fld_val_i[f] == acc_fld_i[f]);
  end

  assign match_o = &fld_ok;

  always_comb begin
    a_r2_wildcard_matches: assert (!(&fld_any_i) || match_o);
  end
endmodule

// File: rtl/mei_corrupt.sv
module mei_corrupt
  import mei_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            valid_i,
  input  logic            hit_i,
  input  logic [HW-1:0]   mask_i,
  input  logic [1:0]      sect_i,
  input  logic            ecc_sel_i,
  input  logic            par_sel_i,
  input  logic [DW-1:0]   data_i,
  input  logic [2*EW-1:0] ecc_i,
  input  logic [1:0]      par_i,
  output logic            valid_o,
  output logic [DW-1:0]   data_o,
  output logic [2*EW-1:0] ecc_o,
  output logic [1:0]      par_o,
  output logic            pulse_o
);
  logic [DW-1:0]   data_n;
  logic [2*EW-1:0] ecc_n;
  logic [1:0]      par_n;
  logic            data_sel;

  assign data_sel = !ecc_sel_i && !par_sel_i;

  for (genvar h = 0; h < 2; h++) begin : g_half
    logic sel;
    assign sel = hit_i && sect_i[h];
    assign data_n[h*HW +: HW] = data_i[h*HW +: HW] ^ ((sel && data_sel) ? mask_i : '0);
    assign ecc_n[h*EW +: EW]  = ecc_i[h*EW +: EW] ^ ((sel && ecc_sel_i) ? mask_i[EW-1:0] : '0);
    assign par_n[h]           = par_i[h] ^ (sel && par_sel_i);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_o <= 1'b0;
      pulse_o <= 1'b0;
      data_o  <= '0;
      ecc_o   <= '0;
      par_o   <= '0;
    end else begin
      valid_o <= valid_i;
      pulse_o <= hit_i;
      data_o  <= data_n;
      ecc_o   <= ecc_n;
      par_o   <= par_n;
    end
  end

  a_r7_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
    valid_i && !hit_i |=> valid_o && data_o == $past(data_i) &&
                          ecc_o == $past(ecc_i) && par_o == $past(par_i));

  a_r3_low_half_only: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && sect_i == 2'b01 |=> data_o[DW-1:HW] == $past(data_i[DW-1:HW]) &&
                                 ecc_o[2*EW-1:EW] == $past(ecc_i[2*EW-1:EW]) &&
                                 par_o[1] == $past(par_i[1]));

  a_r4_ecc_spares_data: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_i && ecc_sel_i |=> data_o == $past(data_i));
endmodule

// File: rtl/mem_err_inject.sv
module mem_err_inject
  import mei_pkg::*;
(
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          reg_valid_i,
  input  logic          reg_write_i,
  input  logic [3:0]    reg_addr_i,
  input  logic [31:0]   reg_wdata_i,
  output logic [31:0]   reg_rdata_o,
  input  logic          acc_valid_i,
  input  logic [1:0]    acc_dimm_i,
  input  logic [1:0]    acc_rank_i,
  input  logic [1:0]    acc_chan_i,
  input  logic [3:0]    acc_bank_i,
  input  logic [15:0]   acc_page_i,
  input  logic [11:0]   acc_col_i,
  input  logic [127:0]  acc_data_i,
  input  logic [15:0]   acc_ecc_i,
  input  logic [1:0]    acc_par_i,
  output logic          acc_valid_o,
  output logic [127:0]  acc_data_o,
  output logic [15:0]   acc_ecc_o,
  output logic [1:0]    acc_par_o,
  output logic          inj_pulse_o,
  output logic [31:0]   inj_count_o
);
  logic [NF-1:0][FW-1:0] fld_val;
  logic [NF-1:0]         fld_any;
  logic [NF-1:0][FW-1:0] acc_fld;
  logic [HW-1:0]         mask;
  logic [1:0]            sect;
  inj_kind_t             kind;
  logic                  en;
  logic                  match;
  logic                  hit;

  assign acc_fld[0] = FW'(acc_dimm_i);
  assign acc_fld[1] = FW'(acc_rank_i);
  assign acc_fld[2] = FW'(acc_chan_i);
  assign acc_fld[3] = FW'(acc_bank_i);
  assign acc_fld[4] = FW'(acc_page_i);
  assign acc_fld[5] = FW'(acc_col_i);

  mei_regs i_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .reg_valid_i (reg_valid_i),
    .reg_write_i (reg_write_i),
    .reg_addr_i  (reg_addr_i),
    .reg_wdata_i (reg_wdata_i),
    .reg_rdata_o (reg_rdata_o),
    .inj_hit_i   (hit),
    .fld_val_o   (fld_val),
    .fld_any_o   (fld_any),
    .mask_o      (mask),
    .sect_o      (sect),
    .kind_o      (kind),
    .en_o        (en),
    .cnt_o       (inj_count_o)
  );

  mei_match i_match (
    .fld_val_i (fld_val),
    .fld_any_i (fld_any),
    .acc_fld_i (acc_fld),
    .match_o   (match)
  );

  assign hit = acc_valid_i && en && match && (sect != 2'b00);

  mei_corrupt i_corrupt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .valid_i   (acc_valid_i),
    .hit_i     (hit),
    .mask_i    (mask),
    .sect_i    (sect),
    .ecc_sel_i (kind.ecc),
    .par_sel_i (kind.par),
    .data_i    (acc_data_i),
    .ecc_i     (acc_ecc_i),
    .par_i     (acc_par_i),
    .valid_o   (acc_valid_o),
    .data_o    (acc_data_o),
    .ecc_o     (acc_ecc_o),
    .par_o     (acc_par_o),
    .pulse_o   (inj_pulse_o)
  );

  a_r6_disabled_no_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en |=> !inj_pulse_o);

  a_r8_count_step: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_pulse_o |-> inj_count_o == $past(inj_count_o) + 32'd1);

  a_r8_count_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_pulse_o |-> $stable(inj_count_o));

  a_r8_pulse_with_valid: assert property (@(posedge clk_i) disable iff (!rst_ni)
    inj_pulse_o |-> acc_valid_o);
endmodule

// File: tb/test_mem_err_inject.sv
module test_mem_err_inject;
  localparam time CLK_PERIOD = 10ns;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         reg_valid = 1'b0, reg_write = 1'b0;
  logic [3:0]   reg_addr = '0;
  logic [31:0]  reg_wdata = '0, reg_rdata;
  logic         acc_valid = 1'b0;
  logic [1:0]   acc_dimm = '0, acc_rank = '0, acc_chan = '0;
  logic [3:0]   acc_bank = '0;
  logic [15:0]  acc_page = '0;
  logic [11:0]  acc_col = '0;
  logic [127:0] acc_data = '0;
  logic [15:0]  acc_ecc = '0;
  logic [1:0]   acc_par = '0;
  logic         acc_valid_o;
  logic [127:0] acc_data_o;
  logic [15:0]  acc_ecc_o;
  logic [1:0]   acc_par_o;
  logic         inj_pulse_o;
  logic [31:0]  inj_count_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  mem_err_inject i_mem_err_inject (
    .clk_i(clk), .rst_ni(rst_n),
    .reg_valid_i(reg_valid), .reg_write_i(reg_write), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata),
    .acc_valid_i(acc_valid), .acc_dimm_i(acc_dimm), .acc_rank_i(acc_rank),
    .acc_chan_i(acc_chan), .acc_bank_i(acc_bank), .acc_page_i(acc_page),
    .acc_col_i(acc_col), .acc_data_i(acc_data), .acc_ecc_i(acc_ecc),
    .acc_par_i(acc_par), .acc_valid_o(acc_valid_o), .acc_data_o(acc_data_o),
    .acc_ecc_o(acc_ecc_o), .acc_par_o(acc_par_o), .inj_pulse_o(inj_pulse_o),
    .inj_count_o(inj_count_o)
  );

  typedef struct {
    logic [127:0] d;
    logic [15:0]  e;
    logic [1:0]   p;
    logic         pl;
    string        tag;
  } exp_t;

  exp_t exp_q[$];
  int   n_chk = 0, n_bad = 0;
  bit   done = 0;

  // reference model state
  logic [15:0] m_val [6];
  bit          m_any [6];
  logic [63:0] m_mask;
  logic [1:0]  m_sect;
  logic [2:0]  m_type;
  bit          m_en;
  int unsigned m_cnt;

  localparam logic [127:0] D0 = 128'h0123_4567_89ab_cdef_fedc_ba98_7654_3210;
  localparam logic [15:0]  E0 = 16'h5a3c;
  localparam logic [1:0]   P0 = 2'b01;

  function automatic logic [15:0] lim(input int f);
    case (f)
      0, 1, 2: return 16'h0003;
      3:       return 16'h000f;
      4:       return 16'hffff;
      default: return 16'h0fff;
    endcase
  endfunction

  task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    if (a < 4'd6) begin m_val[a] = d[15:0] & lim(int'(a)); m_any[a] = d[31]; end
    else if (a == 4'd6) m_mask[31:0] = d;
    else if (a == 4'd7) m_mask[63:32] = d;
    else if (a == 4'd8) begin m_sect = d[1:0]; m_type = d[4:2]; end
    else if (a == 4'd9) m_en = (d != 0);
  endtask

  task automatic reg_rd(input logic [3:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = a;
    #1;
    check(reg_rdata == exp, tag, 64'(reg_rdata), 64'(exp));
    reg_valid = 1'b0;
  endtask

  task automatic access(input logic [1:0] dm, input logic [1:0] rk, input logic [1:0] ch,
                        input logic [3:0] bk, input logic [15:0] pg, input logic [11:0] cl,
                        input logic [127:0] d, input logic [15:0] e, input logic [1:0] p,
                        input string tag);
    logic [15:0] f [6];
    bit hit;
    exp_t x;
    f[0] = 16'(dm); f[1] = 16'(rk); f[2] = 16'(ch);
    f[3] = 16'(bk); f[4] = pg;      f[5] = 16'(cl);
    hit = m_en && (m_sect != 2'b00);
    for (int i = 0; i < 6; i++) if (!m_any[i] && m_val[i] != f[i]) hit = 0;
    x.d = d; x.e = e; x.p = p; x.pl = hit; x.tag = tag;
    if (hit) begin
      for (int h = 0; h < 2; h++) begin
        if (m_sect[h]) begin
          if (m_type[1]) x.e[h*8 +: 8] = x.e[h*8 +: 8] ^ m_mask[7:0];
          if (m_type[2]) x.p[h] = ~x.p[h];
          if (!m_type[1] && !m_type[2]) x.d[h*64 +: 64] = x.d[h*64 +: 64] ^ m_mask;
        end
      end
      m_cnt++;
      if (!m_type[0]) m_en = 0;
    end
    @(negedge clk);
    acc_valid = 1'b1; acc_dimm = dm; acc_rank = rk; acc_chan = ch;
    acc_bank = bk; acc_page = pg; acc_col = cl;
    acc_data = d; acc_ecc = e; acc_par = p;
    exp_q.push_back(x);
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  // monitor / scoreboard
  always @(negedge clk) begin
    if (rst_n && acc_valid_o) begin
      if (exp_q.size() == 0) begin
        check(0, "R7 unexpected output", 64'(acc_valid_o), 64'd0);
      end else begin
        exp_t x;
        x = exp_q.pop_front();
        check(acc_data_o == x.d, {x.tag, " data hi"}, acc_data_o[127:64], x.d[127:64]);
        check(acc_data_o[63:0] == x.d[63:0], {x.tag, " data lo"}, acc_data_o[63:0], x.d[63:0]);
        check(acc_ecc_o == x.e && acc_par_o == x.p, {x.tag, " ecc/par"},
              64'({acc_ecc_o, 2'b00, acc_par_o}), 64'({x.e, 2'b00, x.p}));
        check(inj_pulse_o == x.pl, {x.tag, " R8 pulse"}, 64'(inj_pulse_o), 64'(x.pl));
      end
    end else if (rst_n) begin
      check(!inj_pulse_o, "R8 pulse without output", 64'(inj_pulse_o), 64'd0);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 6; i++) begin m_val[i] = '0; m_any[i] = 1; end
    m_mask = '0; m_sect = '0; m_type = '0; m_en = 0; m_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 6; i++) reg_rd(4'(i), 32'h8000_0000, "R1 field reset");
    reg_rd(4'd6, 32'd0, "R1 mask lo reset");
    reg_rd(4'd7, 32'd0, "R1 mask hi reset");
    reg_rd(4'd8, 32'd0, "R1 ctrl reset");
    reg_rd(4'd9, 32'd0, "R1 enable reset");
    reg_rd(4'd10, 32'd0, "R1 count reset");

    // R6 disabled: pass through
    reg_wr(4'd6, 32'h0000_0040);
    reg_wr(4'd8, 32'h0000_0001);
    access(2'd1, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, P0, "R6 disabled passthrough");

    // R2/R4/R5 one-shot data injection, mask 64 -> bit 6 of lower half
    reg_wr(4'd0, 32'h0000_0001);
    reg_wr(4'd9, 32'h0000_0005);
    access(2'd2, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, P0, "R2 dimm mismatch");
    access(2'd1, 2'd3, 2'd2, 4'd7, 16'h1234, 12'h055, D0, E0, P0, "R4 data bit6 low");
    access(2'd1, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, P0, "R5 one-shot second write");
    reg_rd(4'd9, 32'd0, "R5 one-shot enable cleared");

    // R5 repeat + ECC kind, upper half
    reg_wr(4'd0, 32'h8000_0000);
    reg_wr(4'd6, 32'h0000_00a5);
    reg_wr(4'd8, 32'h0000_000e);  // sect 2, repeat, ecc
    reg_wr(4'd9, 32'h0000_0001);
    access(2'd0, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, P0, "R4 ecc upper 1");
    access(2'd3, 2'd1, 2'd1, 4'd2, 16'd9, 12'd3, D0, ~E0, P0, "R4 ecc upper 2");
    reg_rd(4'd9, 32'd1, "R5 repeat enable held");
    reg_wr(4'd9, 32'h0000_0000);
    access(2'd0, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, P0, "R6 cleared by software");

    // R3/R4 parity on both halves
    reg_wr(4'd8, 32'h0000_0017);  // sect 3, repeat, parity
    reg_wr(4'd9, 32'h0000_0100);
    access(2'd0, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, 2'b01, "R4 parity both");
    access(2'd0, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, 2'b10, "R4 parity both 2");

    // R3 section 0 suppresses and keeps enable
    reg_wr(4'd8, 32'h0000_0004);
    access(2'd0, 2'd0, 2'd0, 4'd0, 16'd0, 12'd0, D0, E0, P0, "R3 section zero");
    reg_rd(4'd9, 32'd1, "R3 section zero keeps enable");

    // R2 all six fields specific, R3 both halves data
    reg_wr(4'd0, 32'h0000_0002);
    reg_wr(4'd1, 32'h0000_0001);
    reg_wr(4'd2, 32'h0000_0003);
    reg_wr(4'd3, 32'h0000_000a);
    reg_wr(4'd4, 32'h0000_beef);
    reg_wr(4'd5, 32'h0000_0abc);
    reg_wr(4'd6, 32'hdead_0001);
    reg_wr(4'd7, 32'h8000_f00d);
    reg_wr(4'd8, 32'h0000_0007);  // sect 3, repeat, data
    access(2'd2, 2'd1, 2'd3, 4'ha, 16'hbeef, 12'habd, D0, E0, P0, "R2 column mismatch");
    access(2'd2, 2'd1, 2'd3, 4'ha, 16'hbeee, 12'habc, D0, E0, P0, "R2 page mismatch");
    access(2'd2, 2'd1, 2'd3, 4'ha, 16'hbeef, 12'habc, D0, E0, P0, "R3 both halves data");
    reg_wr(4'd8, 32'h0000_0006);  // sect 2, repeat
    access(2'd2, 2'd1, 2'd3, 4'ha, 16'hbeef, 12'habc, ~D0, E0, P0, "R3 upper data");
    reg_wr(4'd9, 32'h0000_0000);

    // R9 readback and truncation
    reg_rd(4'd5, 32'h0000_0abc, "R9 column readback");
    reg_rd(4'd7, 32'h8000_f00d, "R9 mask hi readback");
    reg_rd(4'd8, 32'h0000_0006, "R9 ctrl readback");
    reg_wr(4'd0, 32'h8000_ffff);
    reg_rd(4'd0, 32'h8000_0003, "R9 dimm truncation");
    reg_wr(4'd10, 32'h0000_1234);

    // R8 count
    repeat (3) @(negedge clk);
    reg_rd(4'd10, 32'(m_cnt), "R8 count register");
    check(inj_count_o == 32'(m_cnt), "R8 count port", 64'(inj_count_o), 64'(m_cnt));
    check(exp_q.size() == 0, "R7 all outputs seen", 64'(exp_q.size()), 64'd0);

    done = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule